// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Sequencer

This block hands frame buffer base addresses to a capture engine that writes into two alternating address slots. Software, or an upstream agent, submits empty buffer addresses into a circular queue. The sequencer loads up to two of them into the capture slots, tracks which slot the engine fills next, and moves each finished buffer to the consumer side, where it can be popped in completion order.

Three pointers split the queue into regions. Empty buffers lie between the load pointer and the submit pointer. Buffers in flight lie between the completion pointer and the load pointer. Finished buffers lie between the pop pointer and the completion pointer.

Capture only runs while a slot holds a buffer. The block stops capture when it runs out of buffers and restarts it by itself once enough buffers are queued again. When the engine reports both slots finished in the same cycle, the block cannot tell the order, so it rewinds the engine to slot 0.

Top module: `pingpong_fb_seq`

## Requirements
- R1: After reset, `cap_run`, `pop_avail`, `start_ready`, `sub_full`, `frame_done`, `cap_restart` and `cap_skip_first` are all 0.
- R2: A submit is stored only while fewer than QDEPTH buffers are held between the pop and submit pointers. `sub_full`=1 marks a refused submit, and a refused submit changes nothing.
- R3: `start_req` is taken only when the block is not started and at least two empty buffers are queued (`start_ready`=1). The next cycle shows: slot 0 holding the oldest empty buffer, slot 1 the one after it, `slot_sel`=0, `cap_run`=1, and a one-cycle pulse on both `cap_restart` and `cap_skip_first`, which tells the engine to discard the first frame. A refused start has no effect.
- R4: A done pulse on exactly one slot while running gives a one-cycle `frame_done` in the next cycle. If a buffer stays in flight and an empty one is queued, the block loads that empty buffer into slot `slot_sel`, and `slot_sel` then toggles.
- R5: While running with one buffer in flight, no done pulse, and an empty buffer queued, the block loads that buffer into slot `slot_sel` on the next edge.
- R6: When the last in-flight buffer completes, `cap_run` drops to 0 in the next cycle.
- R7: If the block is started but stopped for lack of buffers, it restarts once two empty buffers are queued. It loads both slots as in R3 and pulses `cap_restart`, but not `cap_skip_first`.
- R8: Done pulses on both slots in one cycle produce no `frame_done` and pulse `cap_restart`. With two buffers in flight, the oldest is reloaded into slot 0, the next into slot 1, and `slot_sel` becomes 0. With one in flight, it goes into slot 0 and `slot_sel` becomes 1.
- R9: `pop_avail` is 1 while completed buffers are unpopped. `pop_addr` returns them in submit order. A `pop_req` with `pop_avail`=0 is ignored.
- R10: `stop_req` clears `cap_run` and the started state and returns in-flight buffers to the empty queue. There is no restart until the next accepted `start_req`, which loads those same buffers.
- R11: Done pulses are ignored while `cap_run`=0.
- R12: A submit, a pop and a single done in the same cycle each take effect exactly once.
- R13: No more than two buffers are in flight at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_valid | input | 1 | Submit an empty buffer address |
| sub_addr | input | AW | Address being submitted |
| sub_full | output | 1 | Queue full; a submit this cycle is refused |
| pop_req | input | 1 | Pop one completed buffer |
| pop_avail | output | 1 | A completed buffer is available |
| pop_addr | output | AW | Oldest completed buffer address |
| start_req | input | 1 | Request capture start |
| start_ready | output | 1 | A start this cycle would be accepted |
| stop_req | input | 1 | Stop capture and release slots |
| done0 | input | 1 | Engine finished a frame into slot 0 |
| done1 | input | 1 | Engine finished a frame into slot 1 |
| slot0_addr | output | AW | Buffer address in slot 0 |
| slot1_addr | output | AW | Buffer address in slot 1 |
| slot_sel | output | 1 | Slot that receives the next load |
| cap_run | output | 1 | Capture enabled |
| cap_restart | output | 1 | Pulse: engine restarts at slot 0 |
| cap_skip_first | output | 1 | Pulse: engine discards the first frame |
| frame_done | output | 1 | Pulse: one buffer completed |

## Verification
The hardest states to reach are the two resynchronisation cases: both done flags arriving together, once with two buffers in flight and once with only one. The bench reaches them through a fixed script. It first lets a single completion refill slot 0 with a later buffer, so that the rewind puts visibly different addresses into the slots. It then completes one more frame with the queue empty, leaving a single buffer in flight before the second double pulse. A last step lines up a submit, a pop and a completion on the same edge, with the queue one entry short of full, so that the same-cycle arbitration and the following top-up load are both observed.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;

   // circular increment by comparison (no modulo)
   function automatic int unsigned q_next(input int unsigned p, input int unsigned n);
      return (p + 1 >= n) ? 0 : p + 1;
   endfunction

   // number of entries from a up to (not including) b
   function automatic int unsigned q_dist(input int unsigned a, input int unsigned b,
                                          input int unsigned n);
      return (b >= a) ? (b - a) : (b + n - a);
   endfunction

   typedef enum logic [1:0] {EV_NONE, EV_ONE, EV_BOTH} done_ev_e;

endpackage

// File: rtl/fbseq_store.sv
module fbseq_store #(
   parameter int AW   = 32,
   parameter int PW   = 3,
   parameter int NRD  = 5
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     wa,
   input  logic [AW-1:0]     wd,
   input  logic [NRD*PW-1:0] ra_flat,
   output logic [NRD*AW-1:0] rd_flat
);
   localparam int SLOTS = 1 << PW;

   logic [AW-1:0] mem_q [SLOTS];

   generate
      for (genvar e = 0; e < SLOTS; e++) begin : g_ent
         always_ff @(posedge clk) begin
            if (we && (wa == PW'(e))) mem_q[e] <= wd;
         end
      end
      for (genvar k = 0; k < NRD; k++) begin : g_rd
         assign rd_flat[k*AW +: AW] = mem_q[ra_flat[k*PW +: PW]];
      end
   endgenerate
endmodule

// File: rtl/fbseq_ctrl.sv
module fbseq_ctrl
   import fbseq_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PW      = 3,
   parameter int ENTRIES = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          stop_req,
   input  logic          done0,
   input  logic          done1,
   input  logic [PW-1:0] uw,
   input  logic [AW-1:0] rd_dr,
   input  logic [AW-1:0] rd_dr1,
   input  logic [AW-1:0] rd_dw,
   input  logic [AW-1:0] rd_dw1,
   output logic [PW-1:0] dr_idx,
   output logic [PW-1:0] dr1_idx,
   output logic [PW-1:0] dw_idx,
   output logic [PW-1:0] dw1_idx,
   output logic          start_ready,
   output logic [AW-1:0] slot0_addr,
   output logic [AW-1:0] slot1_addr,
   output logic          slot_sel,
   output logic          cap_run,
   output logic          cap_restart,
   output logic          cap_skip_first,
   output logic          frame_done
);
   logic [PW-1:0] dr_q, dw_q, dr_n, dw_n;
   logic [1:0]    act_q, act_n;
   logic          started_q, started_n, run_q, run_n, sel_q, sel_n;
   logic [AW-1:0] s0_q, s1_q, s0_n, s1_n;
   logic          rst_pl_n, skip_pl_n, fd_n;
   logic          rst_pl_q, skip_pl_q, fd_q;
   logic [PW-1:0] empty_cnt;
   done_ev_e      ev;

   assign dr_idx      = dr_q;
   assign dr1_idx     = PW'(q_next(32'(dr_q), ENTRIES));
   assign dw_idx      = dw_q;
   assign dw1_idx     = PW'(q_next(32'(dw_q), ENTRIES));
   assign empty_cnt   = PW'(q_dist(32'(dr_q), 32'(uw), ENTRIES));
   assign start_ready = !started_q && (empty_cnt >= PW'(2));

   always_comb begin
      if (!run_q)              ev = EV_NONE;
      else if (done0 && done1) ev = EV_BOTH;
      else if (done0 || done1) ev = EV_ONE;
      else                     ev = EV_NONE;
   end

   always_comb begin
      dr_n = dr_q; dw_n = dw_q; act_n = act_q;
      started_n = started_q; run_n = run_q; sel_n = sel_q;
      s0_n = s0_q; s1_n = s1_q;
      rst_pl_n = 1'b0; skip_pl_n = 1'b0; fd_n = 1'b0;
      if (stop_req) begin
         started_n = 1'b0; run_n = 1'b0; dr_n = dw_q; act_n = 2'd0;
      end else if ((start_req && start_ready) ||
                   (started_q && !run_q && empty_cnt >= PW'(2))) begin
         // fresh load of both slots, slot 0 first
         s0_n = rd_dr; s1_n = rd_dr1;
         dr_n = PW'(q_next(32'(dr1_idx), ENTRIES));
         act_n = 2'd2; sel_n = 1'b0;
         run_n = 1'b1; started_n = 1'b1; rst_pl_n = 1'b1;
         skip_pl_n = !started_q;
      end else if (ev == EV_BOTH) begin
         rst_pl_n = 1'b1;
         if (act_q != 2'd0) s0_n = rd_dw;
         if (act_q == 2'd2) begin
            s1_n = rd_dw1; sel_n = 1'b0;
         end else begin
            sel_n = 1'b1;
         end
      end else if (ev == EV_ONE) begin
         dw_n = dw1_idx; fd_n = 1'b1;
         if (act_q == 2'd1) begin
            act_n = 2'd0; run_n = 1'b0;
         end else if (empty_cnt != '0) begin
            if (sel_q) s1_n = rd_dr; else s0_n = rd_dr;
            dr_n = dr1_idx; sel_n = !sel_q;
         end else begin
            act_n = 2'd1;
         end
      end else if (run_q && act_q == 2'd1 && empty_cnt != '0) begin
         if (sel_q) s1_n = rd_dr; else s0_n = rd_dr;
         dr_n = dr1_idx; sel_n = !sel_q; act_n = 2'd2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q <= '0; dw_q <= '0; act_q <= '0;
         started_q <= 1'b0; run_q <= 1'b0; sel_q <= 1'b0;
         s0_q <= '0; s1_q <= '0;
         rst_pl_q <= 1'b0; skip_pl_q <= 1'b0; fd_q <= 1'b0;
      end else begin
         dr_q <= dr_n; dw_q <= dw_n; act_q <= act_n;
         started_q <= started_n; run_q <= run_n; sel_q <= sel_n;
         s0_q <= s0_n; s1_q <= s1_n;
         rst_pl_q <= rst_pl_n; skip_pl_q <= skip_pl_n; fd_q <= fd_n;
      end
   end

   assign slot0_addr     = s0_q;
   assign slot1_addr     = s1_q;
   assign slot_sel       = sel_q;
   assign cap_run        = run_q;
   assign cap_restart    = rst_pl_q;
   assign cap_skip_first = skip_pl_q;
   assign frame_done     = fd_q;

   a_r13_two_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      act_q <= 2'd2);
   a_r3_run_rises_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_run) |-> (act_q == 2'd2 && cap_restart));
   a_r6_stop_empties: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_run) |-> (act_q == 2'd0));
   a_r8_dual_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      (done0 && done1 && cap_run && !stop_req) |=> (cap_restart && !frame_done));
   a_r11_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_run) |=> !frame_done);
endmodule

// File: rtl/pingpong_fb_seq.sv
module pingpong_fb_seq
   import fbseq_pkg::*;
#(
   parameter int AW     = 32,
   parameter int QDEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sub_valid,
   input  logic [AW-1:0] sub_addr,
   output logic          sub_full,
   input  logic          pop_req,
   output logic          pop_avail,
   output logic [AW-1:0] pop_addr,
   input  logic          start_req,
   output logic          start_ready,
   input  logic          stop_req,
   input  logic          done0,
   input  logic          done1,
   output logic [AW-1:0] slot0_addr,
   output logic [AW-1:0] slot1_addr,
   output logic          slot_sel,
   output logic          cap_run,
   output logic          cap_restart,
   output logic          cap_skip_first,
   output logic          frame_done
);
   localparam int ENTRIES = QDEPTH + 1;
   localparam int PW      = $clog2(ENTRIES);
   localparam int NRD     = 5;

   generate
      if (QDEPTH < 2)  begin : g_chk_min  $error("QDEPTH must be at least 2");   end
      if (AW < 1)      begin : g_chk_aw   $error("AW must be positive");         end
      if (QDEPTH > 255) begin : g_chk_max $error("QDEPTH above 255 not allowed"); end
   endgenerate

   logic [PW-1:0]     ur_q, uw_q, dr_i, dr1_i, dw_i, dw1_i;
   logic [NRD*PW-1:0] ra_flat;
   logic [NRD*AW-1:0] rd_flat;
   logic              sub_acc, pop_acc;

   assign sub_full  = (q_dist(32'(ur_q), 32'(uw_q), ENTRIES) == QDEPTH);
   assign sub_acc   = sub_valid && !sub_full;
   assign pop_avail = (ur_q != dw_i);
   assign pop_acc   = pop_req && pop_avail;
   assign ra_flat   = {ur_q, dw1_i, dw_i, dr1_i, dr_i};
   assign pop_addr  = rd_flat[4*AW +: AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ur_q <= '0; uw_q <= '0;
      end else begin
         if (sub_acc) uw_q <= PW'(q_next(32'(uw_q), ENTRIES));
         if (pop_acc) ur_q <= PW'(q_next(32'(ur_q), ENTRIES));
      end
   end

   fbseq_store #(.AW(AW), .PW(PW), .NRD(NRD)) store_i (
      .clk(clk), .we(sub_acc), .wa(uw_q), .wd(sub_addr),
      .ra_flat(ra_flat), .rd_flat(rd_flat)
   );

   fbseq_ctrl #(.AW(AW), .PW(PW), .ENTRIES(ENTRIES)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
      .done0(done0), .done1(done1), .uw(uw_q),
      .rd_dr(rd_flat[0*AW +: AW]), .rd_dr1(rd_flat[1*AW +: AW]),
      .rd_dw(rd_flat[2*AW +: AW]), .rd_dw1(rd_flat[3*AW +: AW]),
      .dr_idx(dr_i), .dr1_idx(dr1_i), .dw_idx(dw_i), .dw1_idx(dw1_i),
      .start_ready(start_ready), .slot0_addr(slot0_addr), .slot1_addr(slot1_addr),
      .slot_sel(slot_sel), .cap_run(cap_run), .cap_restart(cap_restart),
      .cap_skip_first(cap_skip_first), .frame_done(frame_done)
   );

   a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && sub_full) |=> $stable(uw_q));
   a_r2_held_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_dist(32'(ur_q), 32'(uw_q), ENTRIES) <= QDEPTH);
   a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !pop_avail) |=> $stable(ur_q));
   a_r12_pop_once: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_acc && (done0 || done1)) |=> (ur_q == PW'(q_next(32'($past(ur_q)), ENTRIES))));
endmodule

// File: tb/pingpong_fb_seq_tb_top.sv
module pingpong_fb_seq_tb_top;
   localparam int AW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sub_valid = 0, pop_req = 0, start_req = 0, stop_req = 0, done0 = 0, done1 = 0;
   logic [AW-1:0] sub_addr = '0;
   logic sub_full, pop_avail, start_ready, slot_sel, cap_run, cap_restart, cap_skip_first, frame_done;
   logic [AW-1:0] pop_addr, slot0_addr, slot1_addr;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   logic [AW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   pingpong_fb_seq #(.AW(AW), .QDEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_addr(sub_addr),
      .sub_full(sub_full), .pop_req(pop_req), .pop_avail(pop_avail), .pop_addr(pop_addr),
      .start_req(start_req), .start_ready(start_ready), .stop_req(stop_req),
      .done0(done0), .done1(done1), .slot0_addr(slot0_addr), .slot1_addr(slot1_addr),
      .slot_sel(slot_sel), .cap_run(cap_run), .cap_restart(cap_restart),
      .cap_skip_first(cap_skip_first), .frame_done(frame_done)
   );

   function automatic logic [AW-1:0] aA(int i); return 32'h1000_0000 + 32'(i) * 32'h100; endfunction
   function automatic logic [AW-1:0] aB(int i); return 32'h2000_0000 + 32'(i) * 32'h100; endfunction
   localparam logic [AW-1:0] C0 = 32'h3000_0000;

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(); @(negedge clk); endtask

   // driver: pushes expected item when the submit will be accepted
   task automatic submit(logic [AW-1:0] a);
      if (!sub_full) exp_q.push_back(a);
      sub_valid = 1; sub_addr = a;
      @(negedge clk);
      sub_valid = 0;
   endtask

   // monitor side: compare popped address against scoreboard
   task automatic pop_chk(string req);
      pop_req = 1;
      #1;
      if (pop_avail) begin
         if (exp_q.size() == 0) chk(req, pop_addr, 32'hFFFF_FFFF);
         else chk(req, pop_addr, exp_q.pop_front());
      end
      @(negedge clk);
      pop_req = 0;
   endtask

   task automatic pulse_done(logic d0, logic d1);
      done0 = d0; done1 = d1;
      @(negedge clk);
      done0 = 0; done1 = 0;
   endtask

   task automatic pulse_start(); start_req = 1; @(negedge clk); start_req = 0; endtask
   task automatic pulse_stop();  stop_req = 1;  @(negedge clk); stop_req = 0;  endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 cap_run", 32'(cap_run), 0);
      chk("R1 pop_avail", 32'(pop_avail), 0);
      chk("R1 start_ready", 32'(start_ready), 0);
      chk("R1 sub_full", 32'(sub_full), 0);
      chk("R1 pulses", {29'd0, frame_done, cap_restart, cap_skip_first}, 0);
      // R3 refused start
      pulse_start();
      chk("R3 refused start", 32'(cap_run), 0);
      // R2 fill to full, then refused submit
      for (int i = 0; i < 4; i++) submit(aA(i));
      chk("R2 full", 32'(sub_full), 1);
      submit(32'hDEAD_0000);
      chk("R2 still full", 32'(sub_full), 1);
      // R3 accepted start
      chk("R3 ready", 32'(start_ready), 1);
      pulse_start();
      chk("R3 run", 32'(cap_run), 1);
      chk("R3 slot0", slot0_addr, aA(0));
      chk("R3 slot1", slot1_addr, aA(1));
      chk("R3 sel", 32'(slot_sel), 0);
      chk("R3 skip", 32'(cap_skip_first), 1);
      chk("R3 restart", 32'(cap_restart), 1);
      idle();
      chk("R3 restart pulse ends", 32'(cap_restart), 0);
      // R4 single done with refill
      pulse_done(1, 0);
      chk("R4 frame_done", 32'(frame_done), 1);
      chk("R4 refill slot0", slot0_addr, aA(2));
      chk("R4 sel toggled", 32'(slot_sel), 1);
      pop_chk("R9 first pop");
      pulse_done(0, 1);
      chk("R4 refill slot1", slot1_addr, aA(3));
      chk("R4 sel back", 32'(slot_sel), 0);
      // R6 starve
      pulse_done(1, 0);
      chk("R4 no refill when empty", slot0_addr, aA(2));
      chk("R6 still running", 32'(cap_run), 1);
      pulse_done(0, 1);
      chk("R6 stopped", 32'(cap_run), 0);
      // R11 done ignored while stopped
      pulse_done(0, 1);
      chk("R11 no frame_done", 32'(frame_done), 0);
      for (int i = 0; i < 3; i++) pop_chk("R9 pop order");
      chk("R9 drained", 32'(pop_avail), 0);
      pop_chk("R9 empty pop ignored");
      // R7 auto restart
      submit(aB(0));
      idle();
      chk("R7 one buffer not enough", 32'(cap_run), 0);
      submit(aB(1));
      chk("R7 not yet", 32'(cap_run), 0);
      idle();
      chk("R7 restarted", 32'(cap_run), 1);
      chk("R7 slot0", slot0_addr, aB(0));
      chk("R7 slot1", slot1_addr, aB(1));
      chk("R7 restart pulse", 32'(cap_restart), 1);
      chk("R7 no skip", 32'(cap_skip_first), 0);
      // R8 dual done with two in flight
      submit(aB(2));
      pulse_done(1, 0);
      chk("R4 slot0 B2", slot0_addr, aB(2));
      pop_chk("R9 pop B0");
      pulse_done(1, 1);
      chk("R8 slot0", slot0_addr, aB(1));
      chk("R8 slot1", slot1_addr, aB(2));
      chk("R8 sel", 32'(slot_sel), 0);
      chk("R8 restart", 32'(cap_restart), 1);
      chk("R8 no frame_done", 32'(frame_done), 0);
      // R8 dual done with one in flight
      pulse_done(1, 0);
      chk("R4 frame_done", 32'(frame_done), 1);
      pulse_done(1, 1);
      chk("R8 one slot0", slot0_addr, aB(2));
      chk("R8 one sel", 32'(slot_sel), 1);
      // R5 top-up
      submit(aB(3));
      idle();
      chk("R5 topup slot1", slot1_addr, aB(3));
      chk("R5 sel", 32'(slot_sel), 0);
      // R10 stop
      pulse_stop();
      chk("R10 stopped", 32'(cap_run), 0);
      repeat (3) idle();
      chk("R10 no restart", 32'(cap_run), 0);
      chk("R10 buffers returned", 32'(start_ready), 1);
      pulse_start();
      chk("R10 slot0", slot0_addr, aB(2));
      chk("R10 slot1", slot1_addr, aB(3));
      // R12 submit, pop, done together
      exp_q.push_back(C0);
      done0 = 1; sub_valid = 1; sub_addr = C0; pop_req = 1;
      #1;
      chk("R12 not full", 32'(sub_full), 0);
      chk("R12 pop B1", pop_addr, exp_q.pop_front());
      @(negedge clk);
      done0 = 0; sub_valid = 0; pop_req = 0;
      chk("R12 frame_done", 32'(frame_done), 1);
      idle();
      chk("R12 topup C0", slot0_addr, C0);
      chk("R12 sel", 32'(slot_sel), 1);
      pop_chk("R12 pop B2");
      chk("R12 pop once", 32'(pop_avail), 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule